// File: doc/BRIEF.md
# RGB Parallel Panel Raster Timing Generator

This block drives a panel that keeps no image memory: a parallel RGB panel that must receive every pixel of every frame. Two counters run on the pixel clock, one stepping across a line and one stepping down the frame. From them the block decodes horizontal sync, vertical sync, a data-valid strobe and the pixel coordinate. Both axes have four programmable segments: the sync pulse width, the porch that follows the sync pulse, the visible span, and the porch that follows the visible span. The sync polarity of each axis is also programmable.

A pixel request goes out one clock before each visible pixel. An upstream source that registers its pixel on that request therefore has the pixel on the bus in the clock where data-valid is high. The block takes a 16-bit 5-6-5 colour word and widens it to three 8-bit channels. Each field is aligned to the top bits of its channel and the unused low bits are zero. A sync-suppress mode serves panels that frame on data-valid alone: both sync outputs stay at their inactive level in that mode.

Top module: `rgb_raster_gen`

## Requirements
- R1: Counting from 0 at the start of a line, a line holds h_sync_w sync clocks, then h_back_w porch clocks, then h_act_w visible clocks, then h_front_w porch clocks. The next line starts after the sum of these four counts (for example 48+88+800+120 = 1056 clocks).
- R2: Counted in lines, a frame follows the same order with the v_* counts: sync lines, then back porch lines, then visible lines, then front porch lines. The frame then wraps to line 0.
- R3: de is 1 only in clocks that lie in the visible span of the line counter and also in the visible span of the frame counter. It is 0 in every porch and sync clock.
- R4: While sync_off is 1, hsync stays at its inactive level and vsync stays at its inactive level.
- R5: Polarity input 1 makes that axis' sync active high. Polarity input 0 makes it active low. The inactive level is the inverse of the active level.
- R6: pix_req is 1 exactly in the clocks whose following clock, in the same line, has de at 1.
- R7: During de, red = {pix_in[15:11],3'b000}, grn = {pix_in[10:5],2'b00} and blu = {pix_in[4:0],3'b000}. Outside de, all three channels are 0.
- R8: During de, pos_x counts 0 to h_act_w-1 from left to right and pos_y counts 0 to v_act_w-1 from top to bottom. Outside de, both are 0.
- R9: frame_start is 1 for exactly one clock: the first clock of line 0, which is the first clock of vertical sync.
- R10: While rst_n is low, and in the first clock after it rises, both counters are at 0. So frame_start is 1, both syncs are active (unless suppressed), and de is 0.
- R11: With the 800-pixel setup of R1, each line has exactly 800 de clocks and the hsync pulse repeats every 1056 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_sync_w | input | FW_H | Line sync pulse width in clocks |
| h_back_w | input | FW_H | Clocks between line sync and first pixel |
| h_act_w | input | FW_H | Visible pixels per line |
| h_front_w | input | FW_H | Clocks between last pixel and next line sync |
| v_sync_w | input | FW_V | Frame sync width in lines |
| v_back_w | input | FW_V | Lines between frame sync and first visible line |
| v_act_w | input | FW_V | Visible lines per frame |
| v_front_w | input | FW_V | Lines after the last visible line |
| h_pol | input | 1 | Line sync active level (1 = high) |
| v_pol | input | 1 | Frame sync active level (1 = high) |
| sync_off | input | 1 | Hold both syncs inactive (data-valid framing only) |
| pix_in | input | 16 | 5-6-5 colour word from the source |
| pix_req | output | 1 | Source must present the next pixel on the following clock |
| de | output | 1 | Visible pixel on the bus |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| frame_start | output | 1 | One-clock marker at the start of a frame |
| pos_x | output | FW_H | Column of the current visible pixel |
| pos_y | output | FW_V | Row of the current visible pixel |
| red | output | 8 | Red channel |
| grn | output | 8 | Green channel |
| blu | output | 8 | Blue channel |

## Verification
The raster is run with four geometries:
- A small, unequal geometry. Every segment boundary, the line wrap and the frame wrap fall within a few hundred clocks.
- A one-pixel-wide geometry with single-clock porches. It separates an off-by-one in the visible window or in the request lead from a correct decode.
- A sync-suppressed run with mixed polarities. It shows whether the suppression and the polarity selection are independent.
- The 800-pixel line. It confirms the 1056-clock period and the visible-pixel count at full width.

The pixel words change every clock. Outside the visible window the source drives all ones, so a channel that leaks data there, or a swapped or shifted colour field, shows up at once.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb565_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb888_t;

    // Align each narrow field to the top of its channel, zero the rest.
    function automatic rgb888_t widen565(rgb565_t p);
        rgb888_t o;
        o.r = {p.r, 3'b000};
        o.g = {p.g, 2'b00};
        o.b = {p.b, 3'b000};
        return o;
    endfunction

endpackage

// File: rtl/axis_phase.sv
`timescale 1ns/1ps
// Segment decode for one raster axis: sync, back porch, visible, front porch.
module axis_phase #(
    parameter int FW = 11,
    localparam int CW = FW + 2
) (
    input  logic [CW-1:0] cnt,
    input  logic [FW-1:0] sync_w,
    input  logic [FW-1:0] back_w,
    input  logic [FW-1:0] act_w,
    input  logic [FW-1:0] front_w,
    output logic          in_sync,
    output logic          in_act,
    output logic          act_next,
    output logic          last,
    output logic [FW-1:0] coord
);
    logic [CW-1:0] act_lo;
    logic [CW-1:0] act_hi;
    logic [CW-1:0] total;
    logic [CW-1:0] nxt;

    always_comb begin
        act_lo   = CW'(sync_w) + CW'(back_w);
        act_hi   = act_lo + CW'(act_w);
        total    = act_hi + CW'(front_w);
        nxt      = cnt + 1'b1;
        in_sync  = cnt < CW'(sync_w);
        in_act   = (cnt >= act_lo) && (cnt < act_hi);
        act_next = (nxt >= act_lo) && (nxt < act_hi);
        last     = cnt >= (total - 1'b1);
        coord    = in_act ? FW'(cnt - act_lo) : '0;
    end
endmodule

// File: rtl/px_expand.sv
`timescale 1ns/1ps
// 5-6-5 to 8-8-8 widening, blanked outside the visible window.
module px_expand (
    input  logic [15:0] pix,
    input  logic        en,
    output logic [7:0]  r,
    output logic [7:0]  g,
    output logic [7:0]  b
);
    import raster_pkg::*;

    rgb888_t wide;

    always_comb begin
        wide = widen565(rgb565_t'(pix));
        if (!en) begin
            wide = '0;
        end
        r = wide.r;
        g = wide.g;
        b = wide.b;
    end
endmodule

// File: rtl/rgb_raster_gen.sv
`timescale 1ns/1ps
module rgb_raster_gen #(
    parameter int FW_H = 11,
    parameter int FW_V = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FW_H-1:0] h_sync_w,
    input  logic [FW_H-1:0] h_back_w,
    input  logic [FW_H-1:0] h_act_w,
    input  logic [FW_H-1:0] h_front_w,
    input  logic [FW_V-1:0] v_sync_w,
    input  logic [FW_V-1:0] v_back_w,
    input  logic [FW_V-1:0] v_act_w,
    input  logic [FW_V-1:0] v_front_w,
    input  logic            h_pol,
    input  logic            v_pol,
    input  logic            sync_off,
    input  logic [15:0]     pix_in,
    output logic            pix_req,
    output logic            de,
    output logic            hsync,
    output logic            vsync,
    output logic            frame_start,
    output logic [FW_H-1:0] pos_x,
    output logic [FW_V-1:0] pos_y,
    output logic [7:0]      red,
    output logic [7:0]      grn,
    output logic [7:0]      blu
);
    localparam int HCW = FW_H + 2;
    localparam int VCW = FW_V + 2;

    typedef struct packed {
        logic [HCW-1:0] hc;
        logic [VCW-1:0] vc;
    } scan_t;

    scan_t st_d, st_q;

    logic h_sync_on, h_act, h_act_nx, h_last;
    logic v_sync_on, v_act, v_act_nx, v_last;
    logic [FW_H-1:0] h_coord;
    logic [FW_V-1:0] v_coord;

    axis_phase #(.FW(FW_H)) u_hax (
        .cnt     (st_q.hc),
        .sync_w  (h_sync_w),
        .back_w  (h_back_w),
        .act_w   (h_act_w),
        .front_w (h_front_w),
        .in_sync (h_sync_on),
        .in_act  (h_act),
        .act_next(h_act_nx),
        .last    (h_last),
        .coord   (h_coord)
    );

    axis_phase #(.FW(FW_V)) u_vax (
        .cnt     (st_q.vc),
        .sync_w  (v_sync_w),
        .back_w  (v_back_w),
        .act_w   (v_act_w),
        .front_w (v_front_w),
        .in_sync (v_sync_on),
        .in_act  (v_act),
        .act_next(v_act_nx),
        .last    (v_last),
        .coord   (v_coord)
    );

    // Next-state: step along the line, wrap to the next line, wrap the frame.
    always_comb begin
        st_d = st_q;
        if (h_last) begin
            st_d.hc = '0;
            st_d.vc = v_last ? '0 : st_q.vc + 1'b1;
        end else begin
            st_d.hc = st_q.hc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Output decode from the registered counters.
    always_comb begin
        de          = h_act && v_act;
        pix_req     = h_act_nx && v_act;
        hsync       = (h_sync_on && !sync_off) ? h_pol : ~h_pol;
        vsync       = (v_sync_on && !sync_off) ? v_pol : ~v_pol;
        frame_start = (st_q.hc == '0) && (st_q.vc == '0);
        pos_x       = de ? h_coord : '0;
        pos_y       = de ? v_coord : '0;
    end

    px_expand u_px (
        .pix(pix_in),
        .en (de),
        .r  (red),
        .g  (grn),
        .b  (blu)
    );

    logic unused_v_nx;
    assign unused_v_nx = v_act_nx;

endmodule

// File: rtl/rgb_raster_chk.sv
`timescale 1ns/1ps
module rgb_raster_chk #(
    parameter int FW_H = 11,
    parameter int FW_V = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            h_pol,
    input logic            v_pol,
    input logic            sync_off,
    input logic            pix_req,
    input logic            de,
    input logic            hsync,
    input logic            vsync,
    input logic            frame_start,
    input logic [FW_H-1:0] pos_x,
    input logic [FW_V-1:0] pos_y,
    input logic [7:0]      red,
    input logic [7:0]      grn,
    input logic [7:0]      blu
);
    // R6: a request is always followed by a visible pixel
    a_r6_req_then_de: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> de);

    // R6: data-valid never rises without a request in the clock before
    a_r6_de_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> $past(pix_req));

    // R4: suppression holds both syncs inactive
    a_r4_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sync_off |-> (hsync == !h_pol) && (vsync == !v_pol));

    // R3: visible pixels never coincide with a sync pulse
    a_r3_de_clear_of_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync == !h_pol) && (vsync == !v_pol));

    // R7: zero low bits while visible, zero channels while blank
    a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (red[2:0] == 3'b000) && (grn[1:0] == 2'b00) && (blu[2:0] == 3'b000));

    a_r7_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> ({red, grn, blu} == 24'h0));

    // R8: columns advance by one across consecutive visible pixels
    a_r8_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (de && $past(de)) |-> (pos_x == FW_H'($past(pos_x) + 1'b1)));

    a_r8_blank_origin: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pos_x == '0) && (pos_y == '0));

    // R9: frame marker lasts one clock and sits inside frame sync
    a_r9_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r9_fs_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !sync_off) |-> (vsync == v_pol) && (hsync == h_pol));

endmodule

bind rgb_raster_gen rgb_raster_chk #(.FW_H(FW_H), .FW_V(FW_V)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_pol      (h_pol),
    .v_pol      (v_pol),
    .sync_off   (sync_off),
    .pix_req    (pix_req),
    .de         (de),
    .hsync      (hsync),
    .vsync      (vsync),
    .frame_start(frame_start),
    .pos_x      (pos_x),
    .pos_y      (pos_y),
    .red        (red),
    .grn        (grn),
    .blu        (blu)
);

// File: tb/tb_rgb_raster_gen.sv
`timescale 1ns/1ps
module tb_rgb_raster_gen;
    localparam int FW_H = 11;
    localparam int FW_V = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [FW_H-1:0] h_sync_w, h_back_w, h_act_w, h_front_w;
    logic [FW_V-1:0] v_sync_w, v_back_w, v_act_w, v_front_w;
    logic h_pol, v_pol, sync_off;
    logic [15:0] pix_in;
    logic pix_req, de, hsync, vsync, frame_start;
    logic [FW_H-1:0] pos_x;
    logic [FW_V-1:0] pos_y;
    logic [7:0] red, grn, blu;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rgb_raster_gen #(.FW_H(FW_H), .FW_V(FW_V)) dut (
        .clk(clk), .rst_n(rst_n),
        .h_sync_w(h_sync_w), .h_back_w(h_back_w), .h_act_w(h_act_w), .h_front_w(h_front_w),
        .v_sync_w(v_sync_w), .v_back_w(v_back_w), .v_act_w(v_act_w), .v_front_w(v_front_w),
        .h_pol(h_pol), .v_pol(v_pol), .sync_off(sync_off), .pix_in(pix_in),
        .pix_req(pix_req), .de(de), .hsync(hsync), .vsync(vsync), .frame_start(frame_start),
        .pos_x(pos_x), .pos_y(pos_y), .red(red), .grn(grn), .blu(blu)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf,
                           logic hp, logic vp, logic so);
        h_sync_w = FW_H'(hs); h_back_w = FW_H'(hb); h_act_w = FW_H'(ha); h_front_w = FW_H'(hf);
        v_sync_w = FW_V'(vs); v_back_w = FW_V'(vb); v_act_w = FW_V'(va); v_front_w = FW_V'(vf);
        h_pol = hp; v_pol = vp; sync_off = so;
    endtask

    // Holds reset, checks the reset state (R10), releases at a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        pix_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R10 frame_start in reset", int'(frame_start), 1);
        chk("R10 de in reset", int'(de), 0);
        chk("R10 hsync in reset", int'(hsync), sync_off ? int'(!h_pol) : int'(h_pol));
        rst_n = 1'b1;
    endtask

    // Reference raster from the requirements; sample n = clocks since release.
    task automatic run_model(int ncyc, output int de_line0, output int hs_period);
        int htot, vtot, hs, hb, ha, vs, vb, va;
        int first_edge, prev_hs_act;
        hs = int'(h_sync_w); hb = int'(h_back_w); ha = int'(h_act_w);
        vs = int'(v_sync_w); vb = int'(v_back_w); va = int'(v_act_w);
        htot = hs + hb + ha + int'(h_front_w);
        vtot = vs + vb + va + int'(v_front_w);
        de_line0 = 0; hs_period = -1; first_edge = -1; prev_hs_act = 0;
        for (int n = 0; n < ncyc; n++) begin
            int h, v, hn, xe, ye, hs_act;
            logic ha_ok, va_ok, de_e, req_e, hsy_e, vsy_e;
            if (n != 0) @(negedge clk);
            h = n % htot;
            v = (n / htot) % vtot;
            hn = h + 1;
            ha_ok = (h >= hs + hb) && (h < hs + hb + ha);
            va_ok = (v >= vs + vb) && (v < vs + vb + va);
            de_e  = ha_ok && va_ok;
            req_e = (hn >= hs + hb) && (hn < hs + hb + ha) && va_ok;
            hsy_e = (h < hs && !sync_off) ? h_pol : !h_pol;
            vsy_e = (v < vs && !sync_off) ? v_pol : !v_pol;
            xe = de_e ? h - hs - hb : 0;
            ye = de_e ? v - vs - vb : 0;
            if (n == 0) chk("R10 frame_start after release", int'(frame_start), 1);
            chk("R1/R4/R5 hsync", int'(hsync), int'(hsy_e));
            chk("R2/R4/R5 vsync", int'(vsync), int'(vsy_e));
            chk("R3 de", int'(de), int'(de_e));
            chk("R6 pix_req", int'(pix_req), int'(req_e));
            chk("R9 frame_start", int'(frame_start), (h == 0 && v == 0) ? 1 : 0);
            chk("R8 pos_x", int'(pos_x), xe);
            chk("R8 pos_y", int'(pos_y), ye);
            chk("R7 red", int'(red), de_e ? int'({pix_in[15:11], 3'b000}) : 0);
            chk("R7 grn", int'(grn), de_e ? int'({pix_in[10:5], 2'b00}) : 0);
            chk("R7 blu", int'(blu), de_e ? int'({pix_in[4:0], 3'b000}) : 0);
            if (de_e && (n / htot) == (vs + vb)) de_line0 += int'(de);
            hs_act = (hsync == h_pol) ? 1 : 0;
            if (hs_act == 1 && prev_hs_act == 0 && n > 0) begin
                if (first_edge < 0) first_edge = n;
                else if (hs_period < 0) hs_period = n - first_edge;
            end
            prev_hs_act = hs_act;
            // Source: registered pixel appears on the clock after a request.
            pix_in = req_e ? 16'((n * 40503 + 7) & 16'hFFFF) : 16'hFFFF;
        end
    endtask

    task automatic t_small();
        int d, p;
        set_cfg(2, 3, 5, 2, 1, 2, 3, 1, 1'b0, 1'b0, 1'b0);
        do_reset();
        run_model(2 * 12 * 7 + 5, d, p);   // R1 R2 across both wraps
        chk("R3 visible pixels in first visible line", d, 5);
    endtask

    task automatic t_narrow_high();
        int d, p;
        set_cfg(1, 1, 1, 1, 2, 1, 2, 3, 1'b1, 1'b1, 1'b0);   // R5 active high
        do_reset();
        run_model(2 * 4 * 8 + 3, d, p);
        chk("R6 single pixel line", d, 1);
    endtask

    task automatic t_sync_off();
        int d, p;
        set_cfg(3, 2, 4, 3, 2, 1, 3, 2, 1'b1, 1'b0, 1'b1);   // R4 suppressed
        do_reset();
        run_model(12 * 8 + 20, d, p);
        chk("R4 no hsync pulse seen", p, -1);
    endtask

    task automatic t_wide();
        int d, p;
        set_cfg(48, 88, 800, 120, 2, 3, 4, 2, 1'b0, 1'b0, 1'b0);
        do_reset();
        run_model(1056 * 11 + 300, d, p);
        chk("R11 de clocks per line", d, 800);
        chk("R11 hsync period", p, 1056);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        set_cfg(2, 3, 5, 2, 1, 2, 3, 1, 1'b0, 1'b0, 1'b0);
        pix_in = 16'hFFFF;
        t_small();
        t_narrow_high();
        t_sync_off();
        t_wide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule